// File: doc/BRIEF.md
# Three-Bit Majority History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a small table of per-branch outcome histories. A few low-order bits of the branch address select the entry, and there is no tag, so branches that share those bits share an entry. Each entry keeps the directions of the last three resolutions of its branch. The guess is "taken" when most of those remembered outcomes were taken.

The front end presents a branch address on the lookup side and reads back a direction bit in the same cycle. When the branch resolves, the back end presents the address again together with the real direction. That outcome is pushed into the entry as the newest bit, and the oldest bit falls off. While doing so, the block scores the guess the table would have made for that resolution. It keeps two saturating tallies: how many guesses were scored and how many of them were right. A run over a trace therefore yields its accuracy directly.

Top module: `maj_branch_predictor`

## Requirements
- R1: A synchronous active-high `rst` sets every history entry to all-untaken, so every lookup then predicts untaken. It also clears both tallies to zero.
- R2: Address bits [5:2] select one of 16 entries. All other address bits have no effect on which entry is read or written.
- R3: `lookup_taken` is 1 exactly when at least two of the selected entry's three history bits are 1 (1 = taken). Example: taken, untaken, taken gives 1.
- R4: On a rising edge with `upd_valid` high, the selected entry becomes {old[1:0], `upd_taken`}, with the newest outcome in bit 0 and old bit 2 dropped. With `upd_valid` low, no entry changes.
- R5: Lookup is combinational. If a lookup and an update select the same entry in the same cycle, the lookup reflects the history from before that update. The new history is visible after the edge.
- R6: `pred_total` increases by one on every edge with `upd_valid` high.
- R7: `pred_correct` increases by one on an update edge exactly when the majority of the updated entry's pre-update history equals `upd_taken`. Otherwise it holds.
- R8: Both 16-bit tallies stop at 65535 and never wrap.
- R9: From reset, a single branch run through four repeats of T,T,T,T,U scores 14 right of 20. A single branch alternating T,U for 20 outcomes scores 1 right of 20.
- R10: An update changes only the entry it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lookup_pc | input | 32 | Address of the branch being predicted |
| lookup_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved outcome is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| pred_total | output | 16 | Saturating count of scored predictions |
| pred_correct | output | 16 | Saturating count of correct scored predictions |

## Verification
Every entry is driven through all eight three-bit histories, and after each pattern all sixteen entries are read back. This separates a wrong vote threshold from a wrong shift direction, and it exposes index decoding faults that would corrupt neighbouring entries. The lookup addresses vary the bits outside [5:2], which shows that aliasing follows only the index bits. A same-entry lookup is taken in the cycle of its update, across both sides of the edge, to separate a bypassing read from a pre-update read. Two periodic traces show the scoring, one where history helps and one where it is always fooled. A long all-taken run drives both tallies into saturation.

// File: rtl/mvbp_pkg.sv
package mvbp_pkg;
   // Number of set bits needed for a taken verdict in an n-bit history.
   function automatic int unsigned vote_threshold(input int unsigned n);
      return (n / 2) + 1;
   endfunction
endpackage

// File: rtl/mvbp_vote.sv
module mvbp_vote #(
   parameter int unsigned HIST_BITS = 3
) (
   input  logic [HIST_BITS-1:0] hist,
   output logic                 taken
);
   localparam int unsigned THRESH = mvbp_pkg::vote_threshold(HIST_BITS);
   localparam int unsigned CW     = $clog2(HIST_BITS + 1);

   generate
      if (HIST_BITS == 3) begin : g_three
         assign taken = (hist[0] & hist[1]) | (hist[0] & hist[2]) | (hist[1] & hist[2]);
      end else begin : g_count
         logic [CW-1:0] ones;
         always_comb begin
            ones = '0;
            for (int i = 0; i < int'(HIST_BITS); i++) begin
               ones = ones + CW'(hist[i]);
            end
         end
         assign taken = (ones >= CW'(THRESH));
      end
   endgenerate
endmodule

// File: rtl/mvbp_hist_table.sv
module mvbp_hist_table #(
   parameter int unsigned IDX_BITS  = 4,
   parameter int unsigned HIST_BITS = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [IDX_BITS-1:0]  rd_idx,
   output logic [HIST_BITS-1:0] rd_hist,
   input  logic                 wr_en,
   input  logic [IDX_BITS-1:0]  wr_idx,
   input  logic                 wr_bit,
   output logic [HIST_BITS-1:0] wr_hist
);
   localparam int unsigned ENTRIES = 1 << IDX_BITS;

   logic [HIST_BITS-1:0] hist_q [ENTRIES];

   generate
      for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_entry
         always_ff @(posedge clk) begin
            if (rst) begin
               hist_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_BITS'(g))) begin
               hist_q[g] <= {hist_q[g][HIST_BITS-2:0], wr_bit};
            end
         end
      end
   endgenerate

   assign rd_hist = hist_q[rd_idx];
   assign wr_hist = hist_q[wr_idx];
endmodule

// File: rtl/mvbp_sat_counter.sv
module mvbp_sat_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= '0;
      end else if (inc && (count != CNT_MAX)) begin
         count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/maj_branch_predictor.sv
module maj_branch_predictor #(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned IDX_LSB   = 2,
   parameter int unsigned IDX_BITS  = 4,
   parameter int unsigned HIST_BITS = 3,
   parameter int unsigned CNT_W     = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PC_W-1:0]  lookup_pc,
   output logic             lookup_taken,
   input  logic             upd_valid,
   input  logic [PC_W-1:0]  upd_pc,
   input  logic             upd_taken,
   output logic [CNT_W-1:0] pred_total,
   output logic [CNT_W-1:0] pred_correct
);
   localparam int unsigned IDX_HI = IDX_LSB + IDX_BITS - 1;

   generate
      if ((HIST_BITS % 2) == 0 || HIST_BITS < 3) begin : g_bad_hist
         $error("HIST_BITS must be odd and at least 3");
      end
      if (IDX_LSB < 1 || IDX_HI >= PC_W - 1) begin : g_bad_idx
         $error("index field must leave address bits above and below it");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic [IDX_BITS-1:0]  lk_idx, up_idx;
   logic [HIST_BITS-1:0] lk_hist, up_hist;
   logic                 upd_pred;
   logic                 upd_hit;
   logic                 unused_pc_bits;

   assign lk_idx = lookup_pc[IDX_HI:IDX_LSB];
   assign up_idx = upd_pc[IDX_HI:IDX_LSB];
   assign unused_pc_bits = ^{lookup_pc[PC_W-1:IDX_HI+1], lookup_pc[IDX_LSB-1:0],
                             upd_pc[PC_W-1:IDX_HI+1], upd_pc[IDX_LSB-1:0]};

   mvbp_hist_table #(.IDX_BITS(IDX_BITS), .HIST_BITS(HIST_BITS)) u_table (
      .clk     (clk),
      .rst     (rst),
      .rd_idx  (lk_idx),
      .rd_hist (lk_hist),
      .wr_en   (upd_valid),
      .wr_idx  (up_idx),
      .wr_bit  (upd_taken),
      .wr_hist (up_hist)
   );

   mvbp_vote #(.HIST_BITS(HIST_BITS)) u_lk_vote (.hist(lk_hist), .taken(lookup_taken));
   mvbp_vote #(.HIST_BITS(HIST_BITS)) u_up_vote (.hist(up_hist), .taken(upd_pred));

   assign upd_hit = upd_valid & (upd_pred == upd_taken);

   mvbp_sat_counter #(.CNT_W(CNT_W)) u_total (
      .clk (clk), .rst (rst), .inc (upd_valid), .count (pred_total)
   );

   mvbp_sat_counter #(.CNT_W(CNT_W)) u_correct (
      .clk (clk), .rst (rst), .inc (upd_hit), .count (pred_correct)
   );
endmodule

// File: rtl/mvbp_checker.sv
module mvbp_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             upd_valid,
   input logic             upd_taken,
   input logic             upd_pred,
   input logic [CNT_W-1:0] pred_total,
   input logic [CNT_W-1:0] pred_correct
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   // R1: reset clears both tallies
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (pred_total == '0 && pred_correct == '0));

   // R6: each update raises the total below the ceiling
   a_r6_total_step: assert property (@(posedge clk) disable iff (rst)
      (upd_valid && pred_total != CNT_MAX) |=> pred_total == CNT_W'($past(pred_total) + 1'b1));

   // R6: no update, no change to the total
   a_r6_total_hold: assert property (@(posedge clk) disable iff (rst)
      !upd_valid |=> $stable(pred_total));

   // R7: a matching guess raises the correct tally
   a_r7_correct_step: assert property (@(posedge clk) disable iff (rst)
      (upd_valid && upd_pred == upd_taken && pred_correct != CNT_MAX)
      |=> pred_correct == CNT_W'($past(pred_correct) + 1'b1));

   // R7: a wrong guess leaves the correct tally alone
   a_r7_no_credit: assert property (@(posedge clk) disable iff (rst)
      (upd_valid && upd_pred != upd_taken) |=> $stable(pred_correct));

   // R8: tallies hold at the ceiling
   a_r8_total_sat: assert property (@(posedge clk) disable iff (rst)
      pred_total == CNT_MAX |=> pred_total == CNT_MAX);

   a_r8_correct_sat: assert property (@(posedge clk) disable iff (rst)
      pred_correct == CNT_MAX |=> pred_correct == CNT_MAX);
endmodule

bind maj_branch_predictor mvbp_checker #(.CNT_W(CNT_W)) u_mvbp_checker (
   .clk          (clk),
   .rst          (rst),
   .upd_valid    (upd_valid),
   .upd_taken    (upd_taken),
   .upd_pred     (upd_pred),
   .pred_total   (pred_total),
   .pred_correct (pred_correct)
);

// File: tb/maj_branch_predictor_bench.sv
module maj_branch_predictor_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NENT = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] lookup_pc = '0;
   logic        lookup_taken;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic [15:0] pred_total, pred_correct;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [2:0] mh [NENT];
   int exp_total, exp_correct;

   always #(CLK_PERIOD/2) clk = ~clk;

   maj_branch_predictor u_maj_branch_predictor (
      .clk (clk), .rst (rst),
      .lookup_pc (lookup_pc), .lookup_taken (lookup_taken),
      .upd_valid (upd_valid), .upd_pc (upd_pc), .upd_taken (upd_taken),
      .pred_total (pred_total), .pred_correct (pred_correct)
   );

   function automatic logic maj3(input logic [2:0] h);
      return ($countones(h) >= 2);
   endfunction

   function automatic logic [31:0] pc_of(input int e, input int salt);
      return (32'(salt) << 6) | (32'(e) << 2) | (32'(salt) & 32'h3);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      upd_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < NENT; i++) mh[i] = 3'b000;
      exp_total = 0;
      exp_correct = 0;
   endtask

   // Called at a negedge; returns at the following negedge.
   task automatic do_update(input logic [31:0] pc, input logic t);
      int e;
      e = int'(pc[5:2]);
      upd_valid = 1'b1;
      upd_pc = pc;
      upd_taken = t;
      if (exp_total < 65535) exp_total++;
      if (maj3(mh[e]) == t && exp_correct < 65535) exp_correct++;
      mh[e] = {mh[e][1:0], t};
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic check_all(input string req, input int salt);
      for (int i = 0; i < NENT; i++) begin
         lookup_pc = pc_of(i, salt);
         #1;
         chk(req, int'(lookup_taken), int'(maj3(mh[i])));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset state
      chk("R1 total", int'(pred_total), 0);
      chk("R1 correct", int'(pred_correct), 0);
      for (int i = 0; i < NENT; i++) begin
         lookup_pc = pc_of(i, 5);
         #1;
         chk("R1 untaken after reset", int'(lookup_taken), 0);
      end

      // R3, R4, R10, R2: every entry through every history, full readback
      for (int e = 0; e < NENT; e++) begin
         for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            do_update(pc_of(e, p + 1), p[2]);
            do_update(pc_of(e, p + 9), p[1]);
            do_update(pc_of(e, p + 3), p[0]);
            lookup_pc = pc_of(e, 1000 + p);
            #1;
            chk("R3 majority of pattern", int'(lookup_taken), int'($countones(3'(p)) >= 2));
            check_all("R10 R2 other entries", 77 + p);
         end
      end
      // R6, R7 tallies after sweep
      #1;
      chk("R6 total after sweep", int'(pred_total), exp_total);
      chk("R7 correct after sweep", int'(pred_correct), exp_correct);

      // R4: upd_valid low changes nothing
      @(negedge clk);
      upd_pc = pc_of(6, 3);
      upd_taken = ~mh[6][0];
      @(negedge clk);
      @(negedge clk);
      check_all("R4 no update when invalid", 12);
      chk("R6 total hold", int'(pred_total), exp_total);

      // R4: shift order; entry 9 gets T,U,U -> majority untaken, then U,T,T -> taken
      @(negedge clk);
      do_update(pc_of(9, 0), 1'b1);
      do_update(pc_of(9, 0), 1'b0);
      do_update(pc_of(9, 0), 1'b0);
      lookup_pc = pc_of(9, 2); #1;
      chk("R4 oldest dropped", int'(lookup_taken), 0);
      do_update(pc_of(9, 0), 1'b1);
      do_update(pc_of(9, 0), 1'b1);
      lookup_pc = pc_of(9, 2); #1;
      chk("R4 newest two taken", int'(lookup_taken), 1);

      // R5: same-entry lookup during update sees pre-update history
      do_reset();
      do_update(pc_of(3, 0), 1'b1);      // history 001 -> untaken
      upd_valid = 1'b1;
      upd_pc = pc_of(3, 4);
      upd_taken = 1'b1;
      lookup_pc = pc_of(3, 8);
      #1;
      chk("R5 pre-update view", int'(lookup_taken), 0);
      @(posedge clk);
      #1;
      chk("R5 post-update view", int'(lookup_taken), 1);
      @(negedge clk);
      upd_valid = 1'b0;
      mh[3] = 3'b011;
      exp_total = 2;
      chk("R7 scored wrong twice", int'(pred_correct), 0);
      chk("R6 total two", int'(pred_total), 2);

      // R9: four taken then one untaken, repeated four times
      do_reset();
      for (int k = 0; k < 20; k++) do_update(pc_of(5, k), (k % 5) != 4);
      chk("R9 TTTTU correct", int'(pred_correct), 14);
      chk("R9 TTTTU model", int'(pred_correct), exp_correct);
      chk("R9 TTTTU total", int'(pred_total), 20);

      // R9: alternating
      do_reset();
      for (int k = 0; k < 20; k++) do_update(pc_of(11, k), (k % 2) == 0);
      chk("R9 TU correct", int'(pred_correct), 1);
      chk("R9 TU total", int'(pred_total), 20);

      // R8: saturation
      do_reset();
      for (int k = 0; k < 65540; k++) do_update(pc_of(2, 0), 1'b1);
      chk("R8 total saturates", int'(pred_total), 65535);
      chk("R8 correct saturates", int'(pred_correct), 65535);
      chk("R8 model agrees", int'(pred_total), exp_total);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule